// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core that finishes each instruction in one clock cycle. It supports a reduced instruction set with three formats. The set covers six register-to-register ALU operations, add-immediate, word load, word store, branch-if-equal and absolute jump. In one cycle the core reads the program counter, the register file and the data memory, and computes the next value of all of them. The new values are committed on the rising edge of the clock.

The core has two memory ports. The instruction port sends out the program counter as an address and takes back the 32-bit instruction word in the same cycle. The data port sends out an address, write data and a write strobe, and takes back read data in the same cycle. Both memories are expected to read combinationally and to write on the rising clock edge. Inside the core are the program counter, a 32-entry register file, the immediate sign extender, the ALU, the next-PC selection and the writeback selection.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, and `dmem_we` stays low for as long as `rst` is high.
- R2: Each instruction finishes in exactly one cycle. For any instruction other than a taken branch or a jump, `imem_addr` advances by 4 on the next edge.
- R3: An R-type instruction (opcode 0x00) writes register rd (bits 15:11) with rs (bits 25:21) op rt (bits 20:16). The operation comes from funct (bits 5:0): ADD 0x20, SUB 0x22, AND 0x24, OR 0x25, XOR 0x26, NOR 0x27.
- R4: ADDI (opcode 0x08) writes register rt with rs plus the 16-bit immediate (bits 15:0), sign-extended to 32 bits.
- R5: LW (opcode 0x23) reads the word at rs plus the sign-extended immediate and writes it into register rt.
- R6: SW (opcode 0x2B) drives `dmem_addr` with rs plus the sign-extended immediate and `dmem_wdata` with register rt, and raises `dmem_we` in that cycle only. No other opcode raises `dmem_we`.
- R7: BEQ (opcode 0x04) sets the next PC to PC+4+(sign-extended immediate × 4) when rs equals rt, and to PC+4 otherwise.
- R8: J (opcode 0x02) sets the next PC to {PC[31:28], bits 25:0 of the instruction, 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: A register write becomes visible only after the clock edge. An instruction that reads the register it writes sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Store strobe, taken at the next rising edge |
| dmem_rdata | input | 32 | Word read from `dmem_addr` |

## Verification
The control-flow assertions assume that the instruction word tracks `imem_addr` within the same cycle, since they compare the next PC with fields of the current `imem_data`. The bench meets this with a combinational instruction array indexed by the PC. Its program uses only aligned word addresses inside that array and inside the data array, so every fetch and every load returns a defined word. The program ends in a branch to itself, which keeps the PC inside the loaded code for the rest of the run.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_NOR = 6'h27;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR
    } alu_op_e;

    typedef struct packed {
        logic    dst_rd;   // destination field: rd (1) or rt (0)
        logic    src_imm;  // second operand: immediate (1) or rt (0)
        logic    load;     // writeback from data memory
        logic    reg_we;
        logic    store;
        logic    branch;
        logic    jump;
        alu_op_e op;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.op = ALU_ADD;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.op = ALU_ADD;
                    FN_SUB:  ctrl.op = ALU_SUB;
                    FN_AND:  ctrl.op = ALU_AND;
                    FN_OR:   ctrl.op = ALU_OR;
                    FN_XOR:  ctrl.op = ALU_XOR;
                    FN_NOR:  ctrl.op = ALU_NOR;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctrl.src_imm = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OPC_LW: begin
                ctrl.src_imm = 1'b1;
                ctrl.load    = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OPC_SW: begin
                ctrl.src_imm = 1'b1;
                ctrl.store   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.op     = ALU_SUB;
            end
            OPC_JUMP: ctrl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic          we,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            regs_q[i] <= regs_d[i];
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    core_state_t st_d, st_q;

    logic [5:0]      opcode, funct;
    logic [RIDX-1:0] f_rs, f_rt, f_rd, wr_idx;
    logic [15:0]     imm16;
    logic [25:0]     imm26;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_val, pc_inc;
    logic            alu_zero;
    ctrl_t           ctrl;

    assign opcode = imem_data[31:26];
    assign f_rs   = imem_data[25:21];
    assign f_rt   = imem_data[20:16];
    assign f_rd   = imem_data[15:11];
    assign funct  = imem_data[5:0];
    assign imm16  = imem_data[15:0];
    assign imm26  = imem_data[25:0];
    assign imm_ext = {{(XLEN-16){imm16[15]}}, imm16};

    sc_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk (clk),
        .ra1 (f_rs),
        .ra2 (f_rt),
        .wa  (wr_idx),
        .wd  (wb_val),
        .we  (ctrl.reg_we && !rst),
        .rd1 (rs_val),
        .rd2 (rt_val)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wr_idx     = ctrl.dst_rd ? f_rd : f_rt;
    assign wb_val     = ctrl.load ? dmem_rdata : alu_y;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.store && !rst;
    assign imem_addr  = st_q.pc;
    assign pc_inc     = st_q.pc + XLEN'(4);

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctrl.jump) begin
            st_d.pc = {st_q.pc[XLEN-1:XLEN-4], imm26, 2'b00};
        end else if (ctrl.branch && alu_zero) begin
            st_d.pc = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
        end else begin
            st_d.pc = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/sc_core_checker.sv
module sc_core_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we
);
    logic [5:0]  opc;
    logic [31:0] sext;
    assign opc  = imem_data[31:26];
    assign sext = {{16{imem_data[15]}}, imem_data[15:0]};

    // R1
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> imem_addr == 32'd0);
    // R1
    a_r1_no_store_in_reset: assert property (@(posedge clk) rst |-> !dmem_we);
    // R6
    a_r6_store_only_sw: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> opc == 6'h2B);
    // R2
    a_r2_sequential_pc: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'h02 && opc != 6'h04) |=> imem_addr == $past(imem_addr) + 32'd4);
    // R8
    a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
        opc == 6'h02 |=> imem_addr == {$past(imem_addr[31:28]), $past(imem_data[25:0]), 2'b00});
    // R7
    a_r7_branch_choice: assert property (@(posedge clk) disable iff (rst)
        opc == 6'h04 |=> (imem_addr == $past(imem_addr) + 32'd4) ||
                         (imem_addr == $past(imem_addr) + 32'd4 + {$past(sext[29:0]), 2'b00}));
endmodule

bind sc_core sc_core_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] exp_mem [64];
    int          seq [30];
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    always #10 clk = ~clk;

    sc_core uut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int idx);
        return {6'h02, 26'(idx)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h, expected 0x%08h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected at most 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        a = 32'd5;
        b = 32'hFFFF_FFFD;
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'hFC00_0000;
            dmem[i] = 32'h0BAD_0000 + 32'(i);
        end
        dmem[6]  = 32'hDEAD_BEEF;
        dmem[7]  = 32'h1234_5678;
        dmem[10] = 32'hA5A5_A5A5;
        dmem[11] = 32'h5A5A_5A5A;
        imem[0]  = enc_i(6'h08, 0, 1, 5);
        imem[1]  = enc_i(6'h08, 0, 2, -3);
        imem[2]  = enc_r(1, 2, 3, 6'h20);
        imem[3]  = enc_r(1, 2, 4, 6'h22);
        imem[4]  = enc_r(1, 2, 5, 6'h24);
        imem[5]  = enc_r(1, 2, 6, 6'h25);
        imem[6]  = enc_r(1, 2, 7, 6'h26);
        imem[7]  = enc_r(1, 2, 8, 6'h27);
        imem[8]  = enc_i(6'h08, 0, 0, 7);
        imem[9]  = enc_i(6'h2B, 0, 3, 0);
        imem[10] = enc_i(6'h2B, 0, 4, 4);
        imem[11] = enc_i(6'h2B, 0, 5, 8);
        imem[12] = enc_i(6'h2B, 0, 6, 12);
        imem[13] = enc_i(6'h2B, 0, 7, 16);
        imem[14] = enc_i(6'h2B, 0, 8, 20);
        imem[15] = enc_i(6'h2B, 0, 0, 24);
        imem[16] = enc_i(6'h08, 0, 9, 40);
        imem[17] = enc_i(6'h23, 9, 10, -12);
        imem[18] = enc_i(6'h2B, 9, 10, -8);
        imem[19] = enc_r(1, 1, 1, 6'h20);
        imem[20] = enc_i(6'h2B, 0, 1, 36);
        imem[21] = enc_i(6'h04, 1, 3, 5);
        imem[22] = enc_i(6'h04, 3, 8, 2);
        imem[23] = enc_i(6'h08, 0, 11, 99);
        imem[24] = enc_i(6'h2B, 0, 11, 40);
        imem[25] = enc_j(28);
        imem[26] = enc_i(6'h2B, 0, 1, 44);
        imem[27] = enc_i(6'h2B, 0, 1, 44);
        imem[28] = enc_i(6'h2B, 0, 9, 48);
        imem[29] = enc_i(6'h04, 0, 0, -1);

        for (int i = 0; i < 64; i++) exp_mem[i] = dmem[i];
        exp_mem[0]  = a + b;
        exp_mem[1]  = a - b;
        exp_mem[2]  = a & b;
        exp_mem[3]  = a | b;
        exp_mem[4]  = a ^ b;
        exp_mem[5]  = ~(a | b);
        exp_mem[6]  = 32'd0;
        exp_mem[8]  = 32'h1234_5678;
        exp_mem[9]  = a + a;
        exp_mem[12] = 32'd40;

        for (int k = 0; k < 30; k++) seq[k] = (k <= 22) ? k : 29;
        seq[23] = 25;
        seq[24] = 28;

        // R1: reset holds PC at 0 with no store
        repeat (3) @(negedge clk);
        check("R1 pc in reset", imem_addr, 32'd0);
        check("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;

        for (int k = 0; k < 30; k++) begin
            string tag;
            tag = (k == 22) ? "R7 not-taken" : (k == 23) ? "R7 taken" :
                  (k == 24) ? "R8 jump" : (k >= 26) ? "R7 backward" : "R2 sequential";
            check(tag, imem_addr, 32'(seq[k] * 4));
            check("R6 store strobe", {31'd0, dmem_we},
                  {31'd0, imem[seq[k]][31:26] == 6'h2B});
            @(negedge clk);
        end

        check("R3 add", dmem[0], exp_mem[0]);
        check("R3 sub", dmem[1], exp_mem[1]);
        check("R3 and", dmem[2], exp_mem[2]);
        check("R3 or", dmem[3], exp_mem[3]);
        check("R3 xor", dmem[4], exp_mem[4]);
        check("R3 nor, R4 sign-extend", dmem[5], exp_mem[5]);
        check("R9 zero register", dmem[6], exp_mem[6]);
        check("R5 load, negative offset", dmem[8], exp_mem[8]);
        check("R10 read old value", dmem[9], exp_mem[9]);
        check("R7 skipped store", dmem[10], exp_mem[10]);
        check("R8 skipped store", dmem[11], exp_mem[11]);
        check("R4 addi", dmem[12], exp_mem[12]);
        for (int i = 13; i < 64; i++) check("R6 untouched word", dmem[i], exp_mem[i]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule